// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port that carries ten-bit frames. Each frame has a low start bit, eight data bits with the least significant bit first, and a high stop bit. It makes no bit clock of its own. An external overflow pulse from a timer is passed through unchanged or halved, depending on a double-rate control, and the result is a sample tick at sixteen times the baud rate. One free-running modulo-16 counter, shared by both directions, counts those ticks. Each wrap of the counter marks a bit boundary.

Transmit timing follows the wraps of the shared counter, not the moment software writes the buffer. A write only arms the transmitter, and the start bit leaves at the next wrap. The receiver, when enabled, watches the line at the sample rate. A detected high-to-low step clears the shared counter at once, so bit boundaries line up with the incoming frame. Each bit is then decided by a two-of-three vote taken at its centre. Completion is reported through a transmit-done flag and a receive-ready flag. A received byte, together with its stop-bit value, is delivered only if the ready flag was clear when the frame ended.

Top module: `uart_xcvr`

## Requirements
- R1: After reset, txd is 1 and ti, ri, rd_data and rx_stop are all 0.
- R2: A transmitted frame is a 0 start bit, then wr_data bit 0 through bit 7, then a 1 stop bit. Each bit lasts 16 sample ticks, and txd is 1 whenever no frame is in progress.
- R3: With dbl_rate=1 every ovf_tick is a sample tick, so a bit lasts 16 ovf_tick pulses. With dbl_rate=0 every second ovf_tick is a sample tick, so a bit lasts 32 pulses.
- R4: After tx_wr, the start bit is driven at the first wrap of the shared modulo-16 counter, within one bit time of the write. Every later bit is driven at the next wrap, and txd changes at no other time.
- R5: ti goes to 1 in the same cycle the stop bit is first driven. It stays 1 until ti_clr is pulsed. A tx_wr while a frame is in progress is ignored.
- R6: A frame is received only if rx_en is 1 when the falling edge on rxd is detected. A frame sent while rx_en is 0 leaves ri at 0.
- R7: A detected falling edge on rxd clears the shared counter, so frames that start at any phase are received correctly. Each bit is the majority of three samples taken at counts 7, 8 and 9.
- R8: If the start bit votes 1, the receiver returns to idle (a false start). A low glitch shorter than a quarter bit therefore produces no byte and no ri.
- R9: At the end of a frame, if ri is 0, the byte is loaded into rd_data, the voted stop bit is loaded into rx_stop, and ri goes to 1. If ri is already 1, the frame is discarded and rd_data and rx_stop keep their values.
- R10: A ti_clr pulse clears ti and an ri_clr pulse clears ri. A set takes priority over a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ovf_tick | input | 1 | One-cycle timer overflow pulse |
| dbl_rate | input | 1 | 1: sample tick on every overflow; 0: on every second overflow |
| tx_wr | input | 1 | Write of the transmit buffer, starts a frame |
| wr_data | input | 8 | Byte to transmit |
| ti_clr | input | 1 | Clears the transmit-done flag |
| rx_en | input | 1 | Receive enable |
| ri_clr | input | 1 | Clears the receive-ready flag |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| ti | output | 1 | Transmit-done flag |
| ri | output | 1 | Receive-ready flag |
| rd_data | output | 8 | Last received byte |
| rx_stop | output | 1 | Stop-bit value of the last received byte |

## Verification
If the shared counter is off by even one count, every transmitted bit boundary moves, and the bench sees it within the first bit after a write, because it measures each txd edge to the clock against a bit time derived from dbl_rate. If the counter is not cleared on a falling edge, or the vote uses the wrong positions, random frame phases make received bytes disagree within a few frames. A wrong ready-flag rule shows at the ports right after the second frame that arrives without a clear, through a changed rd_data or rx_stop.

// File: rtl/uart_xcvr_pkg.sv
package uart_xcvr_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_t;
endpackage

// File: rtl/uart_baud.sv
// Sample tick from the overflow pulse and the shared divide-by-OVS counter.
module uart_baud #(
  parameter int OVS   = 16,
  parameter int CNT_W = $clog2(OVS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ovf_tick,
  input  logic             dbl_rate,
  input  logic             realign,
  output logic             samp_tick,
  output logic             roll,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);

  logic half;

  assign samp_tick = ovf_tick & (dbl_rate | half);
  assign roll      = samp_tick & (cnt == LAST) & ~realign;

  always_ff @(posedge clk) begin
    if (rst) begin
      half <= 1'b0;
      cnt  <= '0;
    end else begin
      if (ovf_tick) half <= ~half;
      if (realign)        cnt <= '0;
      else if (samp_tick) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/uart_tx.sv
// Transmit shifter; all bit changes happen on counter wraps.
module uart_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              roll,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ti_clr,
  output logic              txd,
  output logic              ti
);
  localparam int BC_W = $clog2(DATA_W + 2);
  localparam logic [BC_W-1:0] STOP_IDX = BC_W'(DATA_W + 1);

  logic [DATA_W:0]   sh;
  logic [BC_W-1:0]   bcnt;
  logic              busy;
  logic              ti_set;

  assign ti_set = busy & roll & (bcnt == STOP_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      txd  <= 1'b1;
      busy <= 1'b0;
      bcnt <= '0;
      sh   <= '0;
    end else if (wr && !busy) begin
      sh   <= {1'b1, wdata};
      busy <= 1'b1;
      bcnt <= '0;
    end else if (busy && roll) begin
      if (bcnt == '0) begin
        txd <= 1'b0;
      end else begin
        txd <= sh[0];
        sh  <= {1'b1, sh[DATA_W:1]};
      end
      bcnt <= bcnt + 1'b1;
      if (bcnt == STOP_IDX) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         ti <= 1'b0;
    else if (ti_set) ti <= 1'b1;
    else if (ti_clr) ti <= 1'b0;
  end
endmodule

// File: rtl/uart_rx.sv
// Receiver: edge detect, mid-bit majority vote, frame assembly.
module uart_rx
  import uart_xcvr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  parameter int CNT_W  = $clog2(OVS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              samp_tick,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              rxd,
  input  logic              rx_en,
  input  logic              ri_clr,
  output logic              realign,
  output logic              ri,
  output logic [DATA_W-1:0] rdata,
  output logic              stop_bit
);
  localparam logic [CNT_W-1:0] V0 = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] V1 = CNT_W'(OVS / 2);
  localparam logic [CNT_W-1:0] V2 = CNT_W'(OVS / 2 + 1);
  localparam int NB_W = $clog2(DATA_W);
  localparam logic [NB_W-1:0] NB_LAST = NB_W'(DATA_W - 1);

  rx_state_t         st;
  logic              s1, s2, prev;
  logic [1:0]        v;
  logic              decide, vbit, ri_set;
  logic [DATA_W-1:0] sh;
  logic [NB_W-1:0]   nb;

  assign realign = samp_tick & (st == RX_IDLE) & rx_en & prev & ~s2;
  assign decide  = samp_tick & (cnt == V2) & (st != RX_IDLE);
  assign vbit    = (v[0] & v[1]) | (v[0] & s2) | (v[1] & s2);
  assign ri_set  = decide & (st == RX_STOP) & ~ri;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1   <= 1'b1;
      s2   <= 1'b1;
      prev <= 1'b1;
      v    <= '0;
    end else begin
      s1 <= rxd;
      s2 <= s1;
      if (samp_tick) begin
        prev <= s2;
        if (cnt == V0) v[0] <= s2;
        if (cnt == V1) v[1] <= s2;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= RX_IDLE;
      sh       <= '0;
      nb       <= '0;
      rdata    <= '0;
      stop_bit <= 1'b0;
    end else if (realign) begin
      st <= RX_START;
    end else if (decide) begin
      unique case (st)
        RX_START: begin
          st <= vbit ? RX_IDLE : RX_DATA;
          nb <= '0;
        end
        RX_DATA: begin
          sh <= {vbit, sh[DATA_W-1:1]};
          nb <= nb + 1'b1;
          if (nb == NB_LAST) st <= RX_STOP;
        end
        RX_STOP: begin
          if (!ri) begin
            rdata    <= sh;
            stop_bit <= vbit;
          end
          st <= RX_IDLE;
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         ri <= 1'b0;
    else if (ri_set) ri <= 1'b1;
    else if (ri_clr) ri <= 1'b0;
  end
endmodule

// File: rtl/uart_xcvr.sv
module uart_xcvr #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ovf_tick,
  input  logic              dbl_rate,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ti_clr,
  input  logic              rx_en,
  input  logic              ri_clr,
  input  logic              rxd,
  output logic              txd,
  output logic              ti,
  output logic              ri,
  output logic [DATA_W-1:0] rd_data,
  output logic              rx_stop
);
  localparam int CNT_W = $clog2(OVS);

  logic             samp_tick;
  logic             roll;
  logic             realign;
  logic [CNT_W-1:0] cnt;

  uart_baud #(.OVS(OVS), .CNT_W(CNT_W)) u_baud (
    .clk(clk), .rst(rst), .ovf_tick(ovf_tick), .dbl_rate(dbl_rate),
    .realign(realign), .samp_tick(samp_tick), .roll(roll), .cnt(cnt)
  );

  uart_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst(rst), .roll(roll), .wr(tx_wr), .wdata(wr_data),
    .ti_clr(ti_clr), .txd(txd), .ti(ti)
  );

  uart_rx #(.DATA_W(DATA_W), .OVS(OVS), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst(rst), .samp_tick(samp_tick), .cnt(cnt), .rxd(rxd),
    .rx_en(rx_en), .ri_clr(ri_clr), .realign(realign), .ri(ri),
    .rdata(rd_data), .stop_bit(rx_stop)
  );
endmodule

// File: rtl/uart_xcvr_chk.sv
module uart_xcvr_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              txd,
  input logic              ti,
  input logic              ri,
  input logic              ri_clr,
  input logic [DATA_W-1:0] rd_data,
  input logic              rx_stop,
  input logic              roll,
  input logic              realign,
  input logic [CNT_W-1:0]  cnt
);
  // R4: txd moves only right after a counter wrap
  a_r4_txd_on_roll: assert property (@(posedge clk) disable iff (rst)
    !$stable(txd) |-> $past(roll));

  // R5: the done flag rises together with the high stop bit
  a_r5_ti_with_stop: assert property (@(posedge clk) disable iff (rst)
    $rose(ti) |-> txd);

  // R7: a detected falling edge leaves the shared counter at zero
  a_r7_realign_clears: assert property (@(posedge clk) disable iff (rst)
    realign |=> (cnt == '0));

  // R9: while ri holds, received data and stop bit do not change
  a_r9_hold_data: assert property (@(posedge clk) disable iff (rst)
    ri && !ri_clr |=> $stable(rd_data) && $stable(rx_stop));

  // R10: ri stays set until cleared
  a_r10_ri_sticky: assert property (@(posedge clk) disable iff (rst)
    ri && !ri_clr |=> ri);
endmodule

bind uart_xcvr uart_xcvr_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .txd(txd), .ti(ti), .ri(ri), .ri_clr(ri_clr),
  .rd_data(rd_data), .rx_stop(rx_stop), .roll(roll), .realign(realign),
  .cnt(cnt)
);

// File: tb/uart_xcvr_bench.sv
module uart_xcvr_bench;
  localparam int CLK_PERIOD = 10;
  localparam int OVF_DIV    = 2;

  logic       clk = 1'b0;
  logic       rst;
  logic       ovf_tick;
  logic       dbl_rate;
  logic       tx_wr;
  logic [7:0] wr_data;
  logic       ti_clr;
  logic       rx_en;
  logic       ri_clr;
  logic       rxd;
  logic       txd, ti, ri, rx_stop;
  logic [7:0] rd_data;

  int  n_vec = 0;
  int  n_err = 0;
  bit  done  = 1'b0;

  logic       exp_ri;
  logic [7:0] exp_rd;
  logic       exp_stop;

  uart_xcvr u_uart_xcvr (
    .clk(clk), .rst(rst), .ovf_tick(ovf_tick), .dbl_rate(dbl_rate),
    .tx_wr(tx_wr), .wr_data(wr_data), .ti_clr(ti_clr), .rx_en(rx_en),
    .ri_clr(ri_clr), .rxd(rxd), .txd(txd), .ti(ti), .ri(ri),
    .rd_data(rd_data), .rx_stop(rx_stop)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  initial begin
    ovf_tick = 1'b0;
    forever begin
      repeat (OVF_DIV - 1) @(negedge clk);
      ovf_tick = 1'b1;
      @(negedge clk);
      ovf_tick = 1'b0;
    end
  end

  function automatic int bit_time(input logic dbl);
    return 16 * OVF_DIV * (dbl ? 1 : 2);
  endfunction

  // value on the line for frame position idx (0 start, 1..8 data, 9 stop)
  function automatic logic frame_bit(input logic [7:0] d, input logic stp, input int idx);
    if (idx == 0) return 1'b0;
    if (idx == 9) return stp;
    return d[idx-1];
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_tx(input logic [7:0] d);
    int bp = bit_time(dbl_rate);
    int lat = 0;
    int bad_idle = 0;
    @(negedge clk);
    tx_wr = 1'b1; wr_data = d;
    @(negedge clk);
    tx_wr = 1'b0;
    while (txd !== 1'b0 && lat < 3 * bp) begin
      @(negedge clk);
      lat++;
    end
    // R4: start bit at the first wrap after the write
    check(lat <= bp + 1, "R4 start latency", lat, bp + 1);
    check(ti == 1'b0, "R5 ti low at start", ti, 0);
    for (int i = 1; i <= 9 * bp + bp / 2; i++) begin
      @(negedge clk);
      if (i == 3 * bp + 1) begin
        tx_wr = 1'b1; wr_data = ~d;
      end else begin
        tx_wr = 1'b0;
      end
      if (i % bp == bp / 2)
        check(txd == frame_bit(d, 1'b1, i / bp), "R2/R3 tx bit", txd, frame_bit(d, 1'b1, i / bp));
      if (i == 9 * bp - 1) check(ti == 1'b0, "R5 ti before stop", ti, 0);
      if (i == 9 * bp)     check(ti == 1'b1 && txd == 1'b1, "R5 ti with stop", {ti, txd}, 3);
    end
    ti_clr = 1'b1;
    @(negedge clk);
    ti_clr = 1'b0;
    check(ti == 1'b0, "R10 ti cleared", ti, 0);
    for (int i = 0; i < 2 * bp; i++) begin
      @(negedge clk);
      if (txd !== 1'b1 || ti !== 1'b0) bad_idle++;
    end
    // R5: the write during the frame started nothing
    check(bad_idle == 0, "R5 busy write ignored", bad_idle, 0);
  endtask

  task automatic send_rx(input logic [7:0] d, input logic stp);
    int bp = bit_time(dbl_rate);
    repeat ($urandom_range(bp - 1, 0)) @(negedge clk);
    for (int b = 0; b < 10; b++) begin
      rxd = frame_bit(d, stp, b);
      repeat (bp) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (bp) @(negedge clk);
    if (rx_en && !exp_ri) begin
      exp_ri = 1'b1; exp_rd = d; exp_stop = stp;
    end
    check(ri == exp_ri, "R6/R9 ri", ri, exp_ri);
    check(rd_data == exp_rd, "R7/R9 rd_data", rd_data, exp_rd);
    check(rx_stop == exp_stop, "R9 rx_stop", rx_stop, exp_stop);
  endtask

  task automatic clear_ri;
    @(negedge clk);
    ri_clr = 1'b1;
    @(negedge clk);
    ri_clr = 1'b0;
    exp_ri = 1'b0;
    check(ri == 1'b0, "R10 ri cleared", ri, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_vec++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; dbl_rate = 1'b1; tx_wr = 1'b0; wr_data = '0;
    ti_clr = 1'b0; rx_en = 1'b1; ri_clr = 1'b0; rxd = 1'b1;
    exp_ri = 1'b0; exp_rd = '0; exp_stop = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(txd == 1'b1, "R1 txd", txd, 1);
    check(ti == 1'b0, "R1 ti", ti, 0);
    check(ri == 1'b0, "R1 ri", ri, 0);
    check(rd_data == 8'h00, "R1 rd_data", rd_data, 0);
    check(rx_stop == 1'b0, "R1 rx_stop", rx_stop, 0);

    send_tx(8'hA5);
    send_tx(8'hFF);
    dbl_rate = 1'b0;
    send_tx(8'h01);
    send_tx(8'h00);

    dbl_rate = 1'b1;
    send_rx(8'h3C, 1'b1);
    clear_ri();
    send_rx(8'hC3, 1'b0);            // R9 stop value of 0 is captured
    send_rx(8'h77, 1'b1);            // R9 discarded while ri is set
    clear_ri();
    rx_en = 1'b0;
    send_rx(8'h5A, 1'b1);            // R6 receiver disabled
    rx_en = 1'b1;
    // R8 short low glitch is a false start
    repeat (7) @(negedge clk);
    rxd = 1'b0;
    repeat (3 * bit_time(dbl_rate) / 16) @(negedge clk);
    rxd = 1'b1;
    repeat (12 * bit_time(dbl_rate)) @(negedge clk);
    check(ri == 1'b0, "R8 false start ri", ri, 0);
    check(rd_data == exp_rd, "R8 false start data", rd_data, exp_rd);

    for (int k = 0; k < 16; k++) begin
      dbl_rate = 1'($urandom_range(1, 0));
      send_tx(8'($urandom));
      send_rx(8'($urandom), 1'b1);
      if ($urandom_range(3, 0) != 0) clear_ri();
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule